// File: doc/BRIEF.md
# Infrared Pulse-Distance Frame Decoder

This block receives the output of a demodulated infrared receiver and turns it into address and command words. The receiver output is low while a carrier burst is present and high during a space. The block passes the line through a two-flop synchroniser and reacts to both edges. It times every burst and every space against a free-running counter that advances on a shared tick.

A frame starts with a long burst and a shorter space. These are followed by 32 data bits and one trailing burst. Each bit is a short burst followed by a short or long space. The last byte of a frame must be the bitwise complement of the command byte. A frame that passes this check gives a one-cycle valid pulse, with the new address and command presented in the same cycle. A frame that fails it gives a one-cycle error pulse instead.

Durations are counted in ticks of one sixteenth of the base period T = 562.5 µs. The tick rate is derived from the `CLK_HZ` parameter. The counter is `TS_W` = 10 bits wide, which covers 1024 ticks, about 36 ms. That is more than the longest interval the decoder ever measures.

Top module: `ir_frame_decoder`

## Requirements
- R1: After reset, frame_valid_o and frame_error_o are low, and addr_o and cmd_o are zero.
- R2: A frame is a 9 ms low burst, then a 4.5 ms high space, then 32 bits, then the falling edge that starts a trailing burst. The frame result is reported in the cycle after that falling edge reaches the synchronised line.
- R3: Each bit is a 562.5 µs low burst followed by a high space. A 562.5 µs space encodes 1 and a 1687.5 µs space encodes 0.
- R4: The first 16 bits received form addr_o and the next 8 form cmd_o, each field least-significant bit first. The final 8 bits, also LSB first, carry the complement of the command.
- R5: When the final byte equals the complement of the command, frame_valid_o pulses high for exactly one cycle. addr_o and cmd_o take the new values in that cycle and hold them until the next valid pulse.
- R6: When the final byte differs from the complement of the command, frame_error_o pulses for one cycle, frame_valid_o stays low, and addr_o and cmd_o are unchanged.
- R7: Any burst or space within ±25% of its nominal length is accepted. A frame with every duration scaled by up to ±18%, or jittered independently by up to ±12%, decodes correctly whatever the counter phase.
- R8: A burst or space outside its tolerance window ends the frame without any pulse and without changing addr_o or cmd_o. A following correct frame decodes normally.
- R9: If no edge arrives for 22·T (12.375 ms) while a frame is in progress, the frame is abandoned without a pulse, and a new frame that starts afterwards decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_rx_i | input | 1 | Demodulated receiver line, low during a carrier burst |
| addr_o | output | 16 | Address of the last valid frame |
| cmd_o | output | 8 | Command of the last valid frame |
| frame_valid_o | output | 1 | One-cycle pulse when a frame passes all checks |
| frame_error_o | output | 1 | One-cycle pulse when the complement check fails |

## Verification
The bench goes after the following corner cases:

- **Bit order.** A frame with a single set address bit exposes a decoder that shifts MSB first, because it would report 0x8000 instead of 0x0001.
- **Complement check.** A frame whose final byte is off by one bit must give an error pulse and leave the outputs untouched. A design that skips the check would report a valid pulse with the corrupted command.
- **Tolerance windows.** Frames stretched or shrunk by 18% probe the window edges, where a narrow or skewed window loses frames. Single segments pushed past ±25% show a design that accepts anything.
- **Stalled frame.** A frame that stops mid-way and stays quiet longer than the timeout, followed at once by a full frame, catches a decoder without a timeout. Such a decoder is still waiting for a bit when the new leader arrives and drops the whole next frame.

// File: rtl/ir_dec_pkg.sv
package ir_dec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD_MARK,
    ST_LEAD_SPACE,
    ST_BIT_MARK,
    ST_BIT_SPACE
  } dec_state_e;

  // nominal durations in multiples of the base period T
  localparam int unsigned LEAD_MARK_UNITS  = 16;
  localparam int unsigned LEAD_SPACE_UNITS = 8;
  localparam int unsigned BIT_MARK_UNITS   = 1;
  localparam int unsigned ONE_SPACE_UNITS  = 1;
  localparam int unsigned ZERO_SPACE_UNITS = 3;

endpackage

// File: rtl/ir_sync_edge.sv
module ir_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // idle line is high, so reset to high to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ir_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o =  sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] &  prev_q;

endmodule

// File: rtl/ir_tick_timer.sv
module ir_tick_timer #(
  parameter int unsigned CLKS_PER_TICK = 2,
  parameter int unsigned TS_W          = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] now_o
);

  logic tick;

  generate
    if (CLKS_PER_TICK <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(CLKS_PER_TICK);
      logic [PW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               div_q <= '0;
        else if (div_q == PW'(CLKS_PER_TICK - 1))  div_q <= '0;
        else                                       div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == PW'(CLKS_PER_TICK - 1));
    end
  endgenerate

  // free running, never cleared; intervals use modulo subtraction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   now_o <= '0;
    else if (tick) now_o <= now_o + 1'b1;
  end

endmodule

// File: rtl/ir_frame_fsm.sv
module ir_frame_fsm
  import ir_dec_pkg::*;
#(
  parameter int unsigned TS_W          = 10,
  parameter int unsigned SUBDIV        = 16,
  parameter int unsigned TOL_SHIFT     = 2,
  parameter int unsigned TIMEOUT_UNITS = 22,
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned CMD_W         = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [TS_W-1:0]   now_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              valid_o,
  output logic              error_o
);

  localparam int unsigned FRAME_W = ADDR_W + 2 * CMD_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam int unsigned N_LM    = LEAD_MARK_UNITS  * SUBDIV;
  localparam int unsigned N_LS    = LEAD_SPACE_UNITS * SUBDIV;
  localparam int unsigned N_BM    = BIT_MARK_UNITS   * SUBDIV;
  localparam int unsigned N_ONE   = ONE_SPACE_UNITS  * SUBDIV;
  localparam int unsigned N_ZERO  = ZERO_SPACE_UNITS * SUBDIV;
  localparam int unsigned N_TMO   = TIMEOUT_UNITS    * SUBDIV;

  function automatic logic in_win(input logic [TS_W-1:0] d, input int unsigned nom);
    int unsigned dv;
    int unsigned tol;
    dv  = 32'(d);
    tol = nom >> TOL_SHIFT;
    return (dv >= nom - tol) && (dv <= nom + tol);
  endfunction

  dec_state_e         state_q;
  logic [TS_W-1:0]    ts_q;
  logic [TS_W-1:0]    delta;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] word_next;
  logic               is_one, is_zero, timed_out;
  logic [CMD_W-1:0]   cmd_rx, inv_rx;

  assign delta     = now_i - ts_q;
  assign timed_out = (state_q != ST_IDLE) && (32'(delta) >= N_TMO);
  assign is_one    = in_win(delta, N_ONE);
  assign is_zero   = in_win(delta, N_ZERO);
  assign word_next = {is_one, sr_q[FRAME_W-1:1]};
  assign cmd_rx    = word_next[ADDR_W +: CMD_W];
  assign inv_rx    = word_next[ADDR_W+CMD_W +: CMD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ts_q      <= '0;
      bit_cnt_q <= '0;
      sr_q      <= '0;
      addr_o    <= '0;
      cmd_o     <= '0;
      valid_o   <= 1'b0;
      error_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      error_o <= 1'b0;
      if (rise_i || fall_i) ts_q <= now_i;
      if (timed_out) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE:
            if (fall_i) state_q <= ST_LEAD_MARK;
          ST_LEAD_MARK:
            if (rise_i) state_q <= in_win(delta, N_LM) ? ST_LEAD_SPACE : ST_IDLE;
          ST_LEAD_SPACE:
            if (fall_i) begin
              state_q   <= in_win(delta, N_LS) ? ST_BIT_MARK : ST_IDLE;
              bit_cnt_q <= '0;
            end
          ST_BIT_MARK:
            if (rise_i) state_q <= in_win(delta, N_BM) ? ST_BIT_SPACE : ST_IDLE;
          ST_BIT_SPACE:
            if (fall_i) begin
              if (!(is_one || is_zero)) begin
                state_q <= ST_IDLE;
              end else if (bit_cnt_q == CNT_W'(FRAME_W - 1)) begin
                state_q <= ST_IDLE;
                if (inv_rx == ~cmd_rx) begin
                  valid_o <= 1'b1;
                  addr_o  <= word_next[ADDR_W-1:0];
                  cmd_o   <= cmd_rx;
                end else begin
                  error_o <= 1'b1;
                end
              end else begin
                sr_q      <= word_next;
                bit_cnt_q <= bit_cnt_q + 1'b1;
                state_q   <= ST_BIT_MARK;
              end
            end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ir_frame_decoder.sv
module ir_frame_decoder #(
  parameter int unsigned CLK_HZ        = 250_000_000,
  parameter int unsigned SUBDIV        = 16,
  parameter int unsigned TS_W          = 10,
  parameter int unsigned TOL_SHIFT     = 2,
  parameter int unsigned TIMEOUT_UNITS = 22,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned CMD_W         = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_rx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              frame_valid_o,
  output logic              frame_error_o
);

  // base period T = 9/16000 s, split into SUBDIV ticks
  localparam longint unsigned CPT_RAW =
    (longint'(CLK_HZ) * 64'd9) / (64'd16000 * longint'(SUBDIV));
  localparam int unsigned CLKS_PER_TICK = (CPT_RAW < 64'd1) ? 1 : int'(CPT_RAW);

  logic            rise_w, fall_w;
  logic [TS_W-1:0] now_w;

  ir_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ir_i   (ir_rx_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  ir_tick_timer #(.CLKS_PER_TICK(CLKS_PER_TICK), .TS_W(TS_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .now_o  (now_w)
  );

  ir_frame_fsm #(
    .TS_W(TS_W), .SUBDIV(SUBDIV), .TOL_SHIFT(TOL_SHIFT),
    .TIMEOUT_UNITS(TIMEOUT_UNITS), .ADDR_W(ADDR_W), .CMD_W(CMD_W)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise_w),
    .fall_i  (fall_w),
    .now_i   (now_w),
    .addr_o  (addr_o),
    .cmd_o   (cmd_o),
    .valid_o (frame_valid_o),
    .error_o (frame_error_o)
  );

endmodule

// File: rtl/ir_frame_decoder_chk.sv
module ir_frame_decoder_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CMD_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CMD_W-1:0]  cmd_o,
  input logic              frame_valid_o,
  input logic              frame_error_o,
  input logic              fall_edge_i
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o); // R5

  AST_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_o |-> ($stable(addr_o) && $stable(cmd_o))); // R5

  AST_ERROR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_error_o |=> !frame_error_o); // R6

  AST_VALID_ERROR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_valid_o && frame_error_o)); // R6

  AST_RESULT_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_o || frame_error_o) |-> $past(fall_edge_i)); // R2

endmodule

bind ir_frame_decoder ir_frame_decoder_chk #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_o        (addr_o),
  .cmd_o         (cmd_o),
  .frame_valid_o (frame_valid_o),
  .frame_error_o (frame_error_o),
  .fall_edge_i   (fall_w)
);

// File: tb/ir_frame_decoder_tb_top.sv
module ir_frame_decoder_tb_top;

  localparam int unsigned CLK_HZ_TB = 56889;  // gives 2 clocks per tick
  localparam int U = 32;                      // clocks per base period T

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir = 1'b1;
  logic [15:0] addr;
  logic [7:0]  cmd;
  logic        fv, fe;

  int n_chk = 0, n_fail = 0;
  int vcnt = 0, ecnt = 0;
  int jit_max = 0, fix_pct = 0;
  logic [15:0] exp_addr = '0;
  logic [7:0]  exp_cmd = '0;

  always #2 clk = ~clk;

  ir_frame_decoder #(.CLK_HZ(CLK_HZ_TB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ir_rx_i(ir),
    .addr_o(addr), .cmd_o(cmd), .frame_valid_o(fv), .frame_error_o(fe)
  );

  always @(negedge clk) if (rst_n) begin
    if (fv) vcnt++;
    if (fe) ecnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [15:0] a, input logic [7:0] c, input logic [7:0] inv);
    return {inv, c, a};
  endfunction

  // seg index: 0 leader mark, 1 leader space, 2+2i bit mark, 3+2i bit space
  task automatic seg(input logic lvl, input int units, input int idx, input int bad_seg, input int bad_pct);
    int pct;
    if (idx == bad_seg)  pct = bad_pct;
    else if (jit_max > 0) pct = int'($urandom_range(2 * jit_max)) - jit_max;
    else                 pct = fix_pct;
    ir = lvl;
    repeat ((units * U * (100 + pct)) / 100) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int nbits, input int bad_seg, input int bad_pct, input int stall);
    seg(1'b0, 16, 0, bad_seg, bad_pct);
    seg(1'b1, 8, 1, bad_seg, bad_pct);
    for (int i = 0; i < nbits; i++) begin
      seg(1'b0, 1, 2 + 2 * i, bad_seg, bad_pct);
      seg(1'b1, w[i] ? 1 : 3, 3 + 2 * i, bad_seg, bad_pct);
    end
    if (nbits < 32) begin
      ir = 1'b1;
      repeat (stall) @(negedge clk);
    end else begin
      ir = 1'b0;
      repeat (U) @(negedge clk);
      ir = 1'b1;
      repeat (8 * U) @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic [15:0] a, input logic [7:0] c, input logic [7:0] inv,
                           input int bad_seg, input int bad_pct, input string req);
    int v0, e0;
    bit good, err;
    v0 = vcnt; e0 = ecnt;
    send(mk_word(a, c, inv), 32, bad_seg, bad_pct, 0);
    good = (bad_seg < 0) && (inv == ~c);
    err  = (bad_seg < 0) && (inv != ~c);
    if (good) begin exp_addr = a; exp_cmd = c; end
    chk(vcnt - v0 == (good ? 1 : 0), req, "valid pulses", vcnt - v0, good ? 1 : 0);
    chk(ecnt - e0 == (err ? 1 : 0), req, "error pulses", ecnt - e0, err ? 1 : 0);
    chk(addr == exp_addr, req, "addr", addr, exp_addr);
    chk(cmd == exp_cmd, req, "cmd", cmd, exp_cmd);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] ra;
    logic [7:0]  rc;
    int v0;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(fv == 1'b0, "R1", "valid in reset", fv, 0);
    chk(fe == 1'b0, "R1", "error in reset", fe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(addr == 16'h0, "R1", "addr after reset", addr, 0);
    chk(cmd == 8'h0, "R1", "cmd after reset", cmd, 0);
    chk(fv == 1'b0 && fe == 1'b0, "R1", "pulses after reset", {fv, fe}, 0);

    // R4: single set bits expose field order
    run_frame(16'h0001, 8'h80, 8'h7F, -1, 0, "R4");
    run_frame(16'h8000, 8'h01, 8'hFE, -1, 0, "R4");
    // R3: all ones and mostly zeros
    run_frame(16'hFFFF, 8'hFF, 8'h00, -1, 0, "R3");
    run_frame(16'h0000, 8'h00, 8'hFF, -1, 0, "R3");

    // R2 R5 R7: random frames with independent jitter
    jit_max = 12;
    for (int k = 0; k < 10; k++) begin
      ra = 16'($urandom); rc = 8'($urandom);
      run_frame(ra, rc, ~rc, -1, 0, "R5");
    end
    jit_max = 0;

    // R6: complement mismatch
    rc = 8'h3C;
    run_frame(16'hBEEF, rc, ~rc ^ 8'h10, -1, 0, "R6");
    run_frame(16'h1234, 8'h00, 8'h00, -1, 0, "R6");

    // R7: whole frame scaled to window edges
    fix_pct = 18;  run_frame(16'hA5C3, 8'h5A, 8'hA5, -1, 0, "R7");
    fix_pct = -18; run_frame(16'h3C96, 8'hC4, 8'h3B, -1, 0, "R7");
    fix_pct = 0;

    // R8: single segment out of tolerance
    run_frame(16'h7777, 8'h11, 8'hEE, 0, -40, "R8");   // short leader mark
    run_frame(16'h7777, 8'h11, 8'hEE, 1, 40, "R8");    // long leader space
    run_frame(16'h7777, 8'h11, 8'hEE, 13, 45, "R8");   // bit 5 space between windows
    run_frame(16'h7777, 8'h11, 8'hEE, 20, 50, "R8");   // bit 9 mark too long
    run_frame(16'h2468, 8'h42, 8'hBD, -1, 0, "R8");    // recovery

    // R9: stalled frame, then a complete one
    v0 = vcnt;
    send(mk_word(16'hFFFF, 8'hFF, 8'h00), 10, -1, 0, 30 * U);
    chk(vcnt == v0, "R9", "no pulse on stall", vcnt - v0, 0);
    run_frame(16'hC001, 8'h9D, 8'h62, -1, 0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule